// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This block holds two sets of alarm bytes, one byte per calendar field (seconds, minutes, hours, day of month, month, weekday). Each set is compared against the running time once per second. Bit 7 of every alarm byte decides whether its field takes part in the comparison. Bits 6:0 hold the value to match in the same coded form as the time field.

When all of the fields that take part agree with the time on a one-second tick, and the global enable for that alarm is on, the alarm's sticky flag is raised. Only the first alarm drives the interrupt output. The second alarm raises only its flag. A flag is lowered in one of two ways:
- software writes a 0 to its bit in the status address, or
- when the auto-clear control bit is on, any read strobe of the status address lowers it.

There is no byte for the year. Clearing every per-field enable while the global enable stays on gives an alarm on every tick. The block has plain register-strobe and tick inputs. No data stream passes through it, so it has no valid/ready pairs and no back-pressure: every write or read strobe takes effect on the clock edge where it is high.

Top module: `calalm_top`

## Requirements
- R1: After reset, both flags and the interrupt output are 0, and the control register is 0, so both global alarm enables are off.
- R2: The alarm bytes sit at consecutive addresses, in the order seconds, minutes, hours, day of month, month, weekday. The first alarm uses 0x0C..0x11 and the second uses 0x12..0x17. When its global enable is on and every byte with bit 7 = 1 has bits 6:0 equal to the time field, a tick sets the alarm's flag, which is seen on the clock edge after the tick edge.
- R3: A field whose byte has bit 7 = 0 does not take part in the comparison, whatever its bits 6:0 hold.
- R4: With the global enable on and bit 7 = 0 in all six bytes, every tick sets the flag.
- R5: A matching time with `sec_tick` low never sets a flag.
- R6: A mismatch in any field that takes part in the comparison blocks the flag on that tick.
- R7: The control register is at 0x08. Bit 0 is the first alarm's global enable, bit 1 is the second alarm's global enable, and bit 2 is auto-clear. With an alarm's global enable at 0, a tick never sets that alarm's flag.
- R8: The status address is 0x07, and bit k there belongs to alarm k. A write with 0 in bit k clears flag k. A write with 1 in bit k leaves flag k as it was and never sets it.
- R9: With auto-clear on, a read strobe of 0x07 clears both flags. A read with auto-clear off, or a read of any other address, leaves the flags unchanged.
- R10: The second alarm has the same compare rule as the first and its own global enable. It sets only `alm_flag[1]`.
- R11: `irq_o` is 1 exactly when the first alarm's flag is 1. The second alarm's flag has no effect on `irq_o`.
- R12: If a flag's set condition and its clear happen on the same edge, the set wins.
- R13: A raised flag stays 1, with no clearing write or read, even after the time moves on or the global enable goes off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe, used for auto-clear |
| rd_addr | input | ADDR_W | Read address |
| sec_tick | input | 1 | One-cycle pulse per second from the time counter |
| tm_sec | input | 7 | Current seconds |
| tm_min | input | 7 | Current minutes |
| tm_hour | input | 7 | Current hours |
| tm_date | input | 7 | Current day of month |
| tm_month | input | 7 | Current month |
| tm_dow | input | 7 | Current weekday |
| alm_flag | output | N_ALARMS | Sticky alarm flags |
| irq_o | output | 1 | Interrupt output, high while the first alarm's flag is set |

## Verification
A wrong stored alarm byte or a wrong enable bit only shows up at the ports on the next tick. It appears as a flag that rises one clock after that tick edge when it should not, or that stays low when it should rise. For this reason the bench ends every case with a tick and looks at `alm_flag` on the following edge. A flag register that is stuck, or that clears itself, shows within one cycle of a status write or read. The bench checks the flags right after each such strobe and again after idle cycles.

// File: rtl/calalm_pkg.sv
package calalm_pkg;
  localparam int BYTE_W   = 8;
  localparam int VAL_W    = 7;
  localparam int N_FIELDS = 6;
  localparam int SET_W    = N_FIELDS * BYTE_W;
  localparam int TIME_W   = N_FIELDS * VAL_W;
endpackage

// File: rtl/calalm_regbank.sv
module calalm_regbank
  import calalm_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int N_ALARMS  = 2,
  parameter int ALM_BASE  = 12,
  parameter int CTRL_ADDR = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [BYTE_W-1:0]               wr_data,
  output logic [N_ALARMS-1:0][SET_W-1:0]  alm_bytes,
  output logic [N_ALARMS:0]               ctrl
);
  localparam int CTRL_W = N_ALARMS + 1;

  for (genvar k = 0; k < N_ALARMS; k++) begin : g_set
    for (genvar f = 0; f < N_FIELDS; f++) begin : g_field
      localparam int BYTE_ADDR = ALM_BASE + k * N_FIELDS + f;
      logic [BYTE_W-1:0] byte_q;
      always_ff @(posedge clk) begin
        if (!rst_n)
          byte_q <= '0;
        else if (wr_en && wr_addr == ADDR_W'(BYTE_ADDR))
          byte_q <= wr_data;
      end
      assign alm_bytes[k][f*BYTE_W +: BYTE_W] = byte_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ctrl <= '0;
    else if (wr_en && wr_addr == ADDR_W'(CTRL_ADDR))
      ctrl <= wr_data[CTRL_W-1:0];
  end
endmodule

// File: rtl/calalm_match.sv
module calalm_match
  import calalm_pkg::*;
(
  input  logic [SET_W-1:0]  alm_set,
  input  logic [TIME_W-1:0] tm_now,
  output logic              hit
);
  logic [N_FIELDS-1:0] field_ok;

  for (genvar f = 0; f < N_FIELDS; f++) begin : g_cmp
    logic              use_field;
    logic [VAL_W-1:0]  want;
    assign use_field   = alm_set[f*BYTE_W + VAL_W];
    assign want        = alm_set[f*BYTE_W +: VAL_W];
    assign field_ok[f] = !use_field || (want == tm_now[f*VAL_W +: VAL_W]);
  end

  assign hit = &field_ok;
endmodule

// File: rtl/calalm_flag.sv
module calalm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      flag_o <= 1'b0;
    else if (set_i)
      flag_o <= 1'b1;
    else if (clr_i)
      flag_o <= 1'b0;
  end
endmodule

// File: rtl/calalm_top.sv
module calalm_top
  import calalm_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int N_ALARMS  = 2,
  parameter int ALM_BASE  = 12,
  parameter int CTRL_ADDR = 8,
  parameter int STAT_ADDR = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic                sec_tick,
  input  logic [VAL_W-1:0]    tm_sec,
  input  logic [VAL_W-1:0]    tm_min,
  input  logic [VAL_W-1:0]    tm_hour,
  input  logic [VAL_W-1:0]    tm_date,
  input  logic [VAL_W-1:0]    tm_month,
  input  logic [VAL_W-1:0]    tm_dow,
  output logic [N_ALARMS-1:0] alm_flag,
  output logic                irq_o
);
  localparam int AUTO_BIT = N_ALARMS;

  logic [N_ALARMS-1:0][SET_W-1:0] alm_bytes;
  logic [N_ALARMS:0]              ctrl_q;
  logic [TIME_W-1:0]              tm_now;
  logic                           stat_wr;
  logic                           stat_rd_clr;

  assign tm_now = {tm_dow, tm_month, tm_date, tm_hour, tm_min, tm_sec};

  calalm_regbank #(
    .ADDR_W   (ADDR_W),
    .N_ALARMS (N_ALARMS),
    .ALM_BASE (ALM_BASE),
    .CTRL_ADDR(CTRL_ADDR)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .alm_bytes(alm_bytes),
    .ctrl     (ctrl_q)
  );

  assign stat_wr     = wr_en && wr_addr == ADDR_W'(STAT_ADDR);
  assign stat_rd_clr = rd_en && rd_addr == ADDR_W'(STAT_ADDR) && ctrl_q[AUTO_BIT];

  for (genvar k = 0; k < N_ALARMS; k++) begin : g_alarm
    logic hit, set_c, clr_c;

    calalm_match u_match (
      .alm_set(alm_bytes[k]),
      .tm_now (tm_now),
      .hit    (hit)
    );

    assign set_c = sec_tick && ctrl_q[k] && hit;
    assign clr_c = (stat_wr && !wr_data[k]) || stat_rd_clr;

    calalm_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_c),
      .clr_i (clr_c),
      .flag_o(alm_flag[k])
    );
  end

  assign irq_o = alm_flag[0];
endmodule

// File: rtl/calalm_chk.sv
module calalm_chk
  import calalm_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int N_ALARMS  = 2,
  parameter int STAT_ADDR = 7
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   wr_addr,
  input logic [BYTE_W-1:0]   wr_data,
  input logic                rd_en,
  input logic [ADDR_W-1:0]   rd_addr,
  input logic                sec_tick,
  input logic [N_ALARMS-1:0] alm_flag,
  input logic                a1_en,
  input logic                autoclr,
  input logic [SET_W-1:0]    a1_bytes
);
  logic [N_FIELDS-1:0] use_bits;
  for (genvar f = 0; f < N_FIELDS; f++) begin : g_use
    assign use_bits[f] = a1_bytes[f*BYTE_W + VAL_W];
  end

  logic stat_w, stat_r;
  assign stat_w = wr_en && wr_addr == ADDR_W'(STAT_ADDR);
  assign stat_r = rd_en && rd_addr == ADDR_W'(STAT_ADDR);

  // R5
  assert_no_set_without_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> !$rose(alm_flag[0]));

  // R7
  assert_gate_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !a1_en) |=> !$rose(alm_flag[0]));

  // R4
  assert_every_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && a1_en && use_bits == '0) |=> alm_flag[0]);

  // R8
  assert_write_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_w && !wr_data[0] && !sec_tick) |=> !alm_flag[0]);

  // R9
  assert_read_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_r && autoclr && !sec_tick) |=> alm_flag == '0);

  // R13
  assert_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_flag[0] && !stat_w && !stat_r) |=> alm_flag[0]);
endmodule

bind calalm_top calalm_chk #(
  .ADDR_W   (ADDR_W),
  .N_ALARMS (N_ALARMS),
  .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .rd_en   (rd_en),
  .rd_addr (rd_addr),
  .sec_tick(sec_tick),
  .alm_flag(alm_flag),
  .a1_en   (ctrl_q[0]),
  .autoclr (ctrl_q[N_ALARMS]),
  .a1_bytes(alm_bytes[0])
);

// File: tb/tb_calalm_top.sv
module tb_calalm_top;
  localparam logic [4:0] STAT = 5'h07;
  localparam logic [4:0] CTRL = 5'h08;
  localparam logic [4:0] A1   = 5'h0C;
  localparam logic [4:0] A2   = 5'h12;
  // {alarm bytes weekday..seconds, time weekday..seconds, expected flag}
  localparam int NV = 8;
  localparam logic [96:0] VEC [NV] = '{
    {48'h83_81_81_91_B0_B0, 48'h03_01_01_11_30_30, 1'b1},  // R2 all fields on
    {48'h00_00_00_00_00_00, 48'h03_01_01_11_30_30, 1'b1},  // R4 none on
    {48'h00_00_00_00_00_B0, 48'h03_01_01_11_30_30, 1'b1},  // R3 seconds only
    {48'h00_00_00_00_00_B1, 48'h03_01_01_11_30_30, 1'b0},  // R6 seconds off by one
    {48'h7F_7F_7F_91_B0_45, 48'h03_01_01_11_30_30, 1'b1},  // R3 junk in unused fields
    {48'h83_82_81_91_B0_B0, 48'h03_01_01_11_30_30, 1'b0},  // R6 month mismatch
    {48'h84_00_00_00_00_00, 48'h03_01_01_11_30_30, 1'b0},  // R6 weekday mismatch
    {48'h00_00_81_00_00_00, 48'h03_01_01_11_30_30, 1'b1}   // R2 date only
  };

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, sec_tick = 0;
  logic [4:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [6:0] tm_sec = '0, tm_min = '0, tm_hour = '0, tm_date = '0, tm_month = '0, tm_dow = '0;
  logic [1:0] alm_flag;
  logic irq_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  calalm_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .sec_tick(sec_tick),
    .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour), .tm_date(tm_date),
    .tm_month(tm_month), .tm_dow(tm_dow), .alm_flag(alm_flag), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [4:0] a);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1;
    @(negedge clk); sec_tick = 0;
  endtask

  task automatic set_time(input logic [47:0] t);
    tm_sec = t[6:0];   tm_min = t[14:8];  tm_hour = t[22:16];
    tm_date = t[30:24]; tm_month = t[38:32]; tm_dow = t[46:40];
  endtask

  task automatic load(input logic [4:0] base, input logic [47:0] b);
    for (int f = 0; f < 6; f++) wr(base + 5'(f), b[8*f +: 8]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 flags after reset", {6'd0, alm_flag}, 8'h00);
    chk("R1 irq after reset", {7'd0, irq_o}, 8'h00);
    set_time(48'h03_01_01_11_30_30);
    load(A1, 48'h0);
    tick();
    chk("R1 enable off after reset", {6'd0, alm_flag}, 8'h00);

    wr(CTRL, 8'h01);
    for (int i = 0; i < NV; i++) begin
      wr(STAT, 8'h00);
      load(A1, VEC[i][96:49]);
      set_time(VEC[i][48:1]);
      tick();
      chk($sformatf("R2/R3/R6 vector %0d", i), {7'd0, alm_flag[0]}, {7'd0, VEC[i][0]});
    end

    // R5: matching time, no tick
    load(A1, 48'h0);
    wr(STAT, 8'h00);
    repeat (4) @(negedge clk);
    chk("R5 no tick no flag", {6'd0, alm_flag}, 8'h00);

    // R4 repeated ticks
    tick();
    chk("R4 first tick", {7'd0, alm_flag[0]}, 8'h01);
    wr(STAT, 8'h00);
    set_time(48'h03_01_01_11_30_31);
    tick();
    chk("R4 next tick", {7'd0, alm_flag[0]}, 8'h01);

    // R13 sticky after time change and enable off
    set_time(48'h05_02_09_04_12_44);
    wr(CTRL, 8'h00);
    repeat (3) @(negedge clk);
    chk("R13 sticky", {7'd0, alm_flag[0]}, 8'h01);
    chk("R11 irq with alarm1", {7'd0, irq_o}, 8'h01);

    // R7 global enable off blocks
    wr(STAT, 8'h00);
    tick();
    chk("R7 enable off no flag", {6'd0, alm_flag}, 8'h00);

    // R10 second alarm, R11 irq untouched
    load(A2, 48'h00_00_00_84_00_00);
    set_time(48'h05_02_09_04_12_44);
    wr(CTRL, 8'h02);
    tick();
    chk("R10 second alarm flag", {6'd0, alm_flag}, 8'h02);
    chk("R11 irq ignores alarm2", {7'd0, irq_o}, 8'h00);
    set_time(48'h05_02_09_05_12_44);
    wr(STAT, 8'h00);
    tick();
    chk("R10 second alarm mismatch", {6'd0, alm_flag}, 8'h00);

    // R8 per-bit write clear
    set_time(48'h05_02_09_04_12_44);
    wr(CTRL, 8'h03);
    tick();
    chk("R8 both set", {6'd0, alm_flag}, 8'h03);
    wr(STAT, 8'hFF);
    chk("R8 write ones keeps", {6'd0, alm_flag}, 8'h03);
    wr(STAT, 8'h02);
    chk("R8 clear bit0 only", {6'd0, alm_flag}, 8'h02);
    wr(STAT, 8'hFF);
    chk("R8 write ones no set", {6'd0, alm_flag}, 8'h02);

    // R9 auto-clear by read
    tick();
    rd(STAT);
    chk("R9 read without auto", {6'd0, alm_flag}, 8'h03);
    wr(CTRL, 8'h07);
    rd(CTRL);
    chk("R9 read other address", {6'd0, alm_flag}, 8'h03);
    rd(STAT);
    chk("R9 read auto clears", {6'd0, alm_flag}, 8'h00);

    // R12 set wins over clear
    @(negedge clk);
    sec_tick = 1; wr_en = 1; wr_addr = STAT; wr_data = 8'h00;
    @(negedge clk);
    sec_tick = 0; wr_en = 0;
    chk("R12 set beats clear", {6'd0, alm_flag}, 8'h03);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule